// File: doc/BRIEF.md
# SIMT Structured Divergence Mask Unit

This block keeps track of which lanes of a wave are enabled while the wave runs structured control flow. The sequencer that decodes instructions presents one control operation per cycle: open or close a conditional, flip to the alternate path, open or close a loop, or take a per-lane break or continue. Each operation comes with the index of the wave it belongs to and a bank of per-lane predicate registers, from which one register is chosen and optionally inverted. The unit updates that wave's enabled-lane mask and its private stack of saved masks on the next rising clock edge.

Every resident wave owns a separate current mask, a record of which lanes are still inside the innermost loop, a record of which lanes have left the current iteration, and a stack of saved entries. Conditional entries and loop entries share the stack, so conditionals and loops can nest in any mix. When a loop close finds lanes still inside the loop, the unit raises a one-cycle request to branch back. The caller holds the loop head address. Pushing onto a full stack, popping an empty one, or closing a construct of the wrong kind sets a sticky error flag. The faulting operation changes no state.

Top module: `simt_div_mask`

## Requirements
- R1: After reset, every wave has all lanes enabled and an empty stack, and `loop_back` and `stack_err` are 0.
- R2: Operation code 0 (if) pushes the current mask and sets the mask to the current mask AND the selected predicate. Predicate register k occupies bits [k*LANES +: LANES] of `pred_bank`, and it is inverted when `pred_neg` is 1.
- R3: Operation code 1 (else) enables the lanes that were enabled at the matching if and did not take the then-path. Lanes that broke out of or continued past the enclosing loop stay disabled.
- R4: Operation code 2 (endif) pops the entry and restores the mask held at the matching if, minus lanes that broke out or continued in the enclosing loop.
- R5: Operation code 4 (break) disables the enabled lanes whose selected predicate (after inversion) is 1. Those lanes stay out of the loop until the loop exits.
- R6: Operation code 5 (continue) disables the enabled lanes whose selected predicate (after inversion) is 1 for the rest of the current iteration only.
- R7: Operation code 3 (loop) pushes a loop entry. At operation code 6 (endloop), if any lane is still in the loop, `loop_back` is 1 in the cycle after the operation and the mask becomes the set of lanes still in the loop, continued lanes included. Otherwise `loop_back` stays 0, the entry is popped, and the mask returns to the set enabled at loop entry.
- R8: Conditionals and loops nest in any mix to DEPTH (default 32) levels on each wave.
- R9: An operation on one wave never changes the state of any other wave.
- R10: A push at DEPTH entries, a pop from an empty stack, or a close whose kind does not match the top entry sets the sticky `stack_err` flag and leaves the wave's state unchanged.
- R11: Code 7 and any cycle with `op_valid` 0 change nothing. `active_mask` always shows the selected wave's mask after every operation accepted at earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A control operation is presented this cycle |
| op_code | input | 3 | Operation: 0 if, 1 else, 2 endif, 3 loop, 4 break, 5 continue, 6 endloop, 7 none |
| wave_sel | input | $clog2(WAVES) | Wave the operation applies to, and the wave shown on `active_mask` |
| pred_bank | input | PREDS*LANES | All predicate registers of the selected wave, register-major |
| pred_sel | input | $clog2(PREDS) | Predicate register used by the operation |
| pred_neg | input | 1 | Invert the selected predicate before use |
| active_mask | output | LANES | Current enabled lanes of the selected wave |
| loop_back | output | 1 | One-cycle request to branch to the loop head |
| stack_err | output | 1 | Sticky overflow, underflow or mismatch flag |

## Verification
Single-level conditionals are driven with mixed, inverted and all-zero predicates. These separate correct predicate selection and inversion from a mask that only narrows. Loops are driven with breaks and continues issued directly and from inside a nested conditional. These show that a later endif does not revive a lane that has left the loop, and that continued lanes come back at the next iteration while broken lanes do not. Operations on different waves are interleaved to catch shared state. A deep run of alternating conditionals and loops, followed by one push too many and by pops from an empty stack, tests the depth limit and confirms that a fault leaves the mask untouched.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

  typedef enum logic [2:0] {
    OP_IF      = 3'd0,
    OP_ELSE    = 3'd1,
    OP_ENDIF   = 3'd2,
    OP_LOOP    = 3'd3,
    OP_BREAK   = 3'd4,
    OP_CONT    = 3'd5,
    OP_ENDLOOP = 3'd6,
    OP_NONE    = 3'd7
  } ctl_op_e;

endpackage

// File: rtl/simt_pred_pick.sv
module simt_pred_pick #(
  parameter int LANES = 8,
  parameter int PREDS = 4,
  parameter int PSW   = (PREDS > 1) ? $clog2(PREDS) : 1
) (
  input  logic [PREDS*LANES-1:0] bank,
  input  logic [PSW-1:0]         sel,
  input  logic                   neg,
  output logic [LANES-1:0]       lanes
);

  // Pick register sel, then invert it when asked.
  function automatic logic [LANES-1:0] pick(input logic [PREDS*LANES-1:0] b,
                                            input logic [PSW-1:0] s,
                                            input logic n);
    return b[s*LANES +: LANES] ^ {LANES{n}};
  endfunction

  assign lanes = pick(bank, sel, neg);

endmodule

// File: rtl/simt_mask_step.sv
module simt_mask_step
  import simt_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 32,
  parameter int SPW   = $clog2(DEPTH + 1),
  parameter int EW    = 3 * LANES + 1
) (
  input  logic [2:0]       op_code,
  input  logic [LANES-1:0] pl,
  input  logic [LANES-1:0] cur,
  input  logic [LANES-1:0] live,
  input  logic [LANES-1:0] off,
  input  logic [EW-1:0]    top,
  input  logic [SPW-1:0]   sp,
  output logic [LANES-1:0] nxt_cur,
  output logic [LANES-1:0] nxt_live,
  output logic [LANES-1:0] nxt_off,
  output logic             do_push,
  output logic             do_pop,
  output logic [EW-1:0]    push_ent,
  output logic             go_back,
  output logic             fault
);

  // Entry layout: [EW-1] loop kind, then fields a, b, c from high to low.
  function automatic logic ent_is_loop(input logic [EW-1:0] e);
    return e[EW-1];
  endfunction
  function automatic logic [LANES-1:0] ent_a(input logic [EW-1:0] e);
    return e[2*LANES +: LANES];
  endfunction
  function automatic logic [LANES-1:0] ent_b(input logic [EW-1:0] e);
    return e[LANES +: LANES];
  endfunction
  function automatic logic [LANES-1:0] ent_c(input logic [EW-1:0] e);
    return e[0 +: LANES];
  endfunction
  function automatic logic [EW-1:0] mk_ent(input logic k, input logic [LANES-1:0] a,
                                           input logic [LANES-1:0] b,
                                           input logic [LANES-1:0] c);
    return {k, a, b, c};
  endfunction
  // Lanes that leave: currently enabled and predicate set.
  function automatic logic [LANES-1:0] leavers(input logic [LANES-1:0] m,
                                               input logic [LANES-1:0] p);
    return m & p;
  endfunction

  ctl_op_e opc;
  logic    full, empty;

  assign opc   = ctl_op_e'(op_code);
  assign full  = (sp == SPW'(DEPTH));
  assign empty = (sp == '0);

  always_comb begin
    nxt_cur  = cur;
    nxt_live = live;
    nxt_off  = off;
    do_push  = 1'b0;
    do_pop   = 1'b0;
    push_ent = '0;
    go_back  = 1'b0;
    fault    = 1'b0;
    case (opc)
      OP_IF: begin
        if (full) fault = 1'b1;
        else begin
          do_push  = 1'b1;
          push_ent = mk_ent(1'b0, cur, leavers(cur, pl), '0);
          nxt_cur  = cur & pl;
        end
      end
      OP_ELSE: begin
        if (empty || ent_is_loop(top)) fault = 1'b1;
        else nxt_cur = ent_a(top) & ~ent_b(top) & ~off;
      end
      OP_ENDIF: begin
        if (empty || ent_is_loop(top)) fault = 1'b1;
        else begin
          do_pop  = 1'b1;
          nxt_cur = ent_a(top) & ~off;
        end
      end
      OP_LOOP: begin
        if (full) fault = 1'b1;
        else begin
          do_push  = 1'b1;
          push_ent = mk_ent(1'b1, cur, live, off);
          nxt_live = cur;
          nxt_off  = '0;
        end
      end
      OP_BREAK: begin
        nxt_cur  = cur & ~pl;
        nxt_live = live & ~leavers(cur, pl);
        nxt_off  = off | leavers(cur, pl);
      end
      OP_CONT: begin
        nxt_cur = cur & ~pl;
        nxt_off = off | leavers(cur, pl);
      end
      OP_ENDLOOP: begin
        if (empty || !ent_is_loop(top)) fault = 1'b1;
        else if (live != '0) begin
          go_back = 1'b1;
          nxt_cur = live;
          nxt_off = '0;
        end else begin
          do_pop   = 1'b1;
          nxt_cur  = ent_a(top);
          nxt_live = ent_b(top);
          nxt_off  = ent_c(top);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/simt_wave_ctx.sv
module simt_wave_ctx #(
  parameter int LANES = 8,
  parameter int DEPTH = 32,
  parameter int SPW   = $clog2(DEPTH + 1),
  parameter int EW    = 3 * LANES + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             push,
  input  logic             pop,
  input  logic [LANES-1:0] nxt_cur,
  input  logic [LANES-1:0] nxt_live,
  input  logic [LANES-1:0] nxt_off,
  input  logic [EW-1:0]    push_ent,
  output logic [LANES-1:0] cur,
  output logic [LANES-1:0] live,
  output logic [LANES-1:0] off,
  output logic [EW-1:0]    top,
  output logic [SPW-1:0]   sp
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_m1;

  assign sp_m1 = sp - SPW'(1);
  assign top   = (sp == '0) ? '0 : mem[sp_m1[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '1;
      live <= '1;
      off  <= '0;
      sp   <= '0;
    end else if (en) begin
      cur  <= nxt_cur;
      live <= nxt_live;
      off  <= nxt_off;
      if (push)     sp <= sp + SPW'(1);
      else if (pop) sp <= sp_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (en && push) mem[sp[AW-1:0]] <= push_ent;
  end

  // R8
  sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));

  // R10
  no_push_pop_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !(push && pop));

endmodule

// File: rtl/simt_div_mask.sv
module simt_div_mask
  import simt_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WAVES = 4,
  parameter int DEPTH = 32,
  parameter int PREDS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  op_valid,
  input  logic [2:0]                            op_code,
  input  logic [((WAVES > 1) ? $clog2(WAVES) : 1)-1:0] wave_sel,
  input  logic [PREDS*LANES-1:0]                pred_bank,
  input  logic [((PREDS > 1) ? $clog2(PREDS) : 1)-1:0] pred_sel,
  input  logic                                  pred_neg,
  output logic [LANES-1:0]                      active_mask,
  output logic                                  loop_back,
  output logic                                  stack_err
);

  localparam int WSW = (WAVES > 1) ? $clog2(WAVES) : 1;
  localparam int PSW = (PREDS > 1) ? $clog2(PREDS) : 1;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int EW  = 3 * LANES + 1;

  logic [LANES-1:0] w_cur  [WAVES];
  logic [LANES-1:0] w_live [WAVES];
  logic [LANES-1:0] w_off  [WAVES];
  logic [EW-1:0]    w_top  [WAVES];
  logic [SPW-1:0]   w_sp   [WAVES];

  logic [LANES-1:0] sel_pl;
  logic [LANES-1:0] nxt_cur, nxt_live, nxt_off;
  logic [EW-1:0]    push_ent;
  logic             do_push, do_pop, go_back, fault;
  logic             accept;

  simt_pred_pick #(.LANES(LANES), .PREDS(PREDS), .PSW(PSW)) u_pick (
    .bank  (pred_bank),
    .sel   (pred_sel),
    .neg   (pred_neg),
    .lanes (sel_pl)
  );

  simt_mask_step #(.LANES(LANES), .DEPTH(DEPTH), .SPW(SPW), .EW(EW)) u_step (
    .op_code  (op_code),
    .pl       (sel_pl),
    .cur      (w_cur[wave_sel]),
    .live     (w_live[wave_sel]),
    .off      (w_off[wave_sel]),
    .top      (w_top[wave_sel]),
    .sp       (w_sp[wave_sel]),
    .nxt_cur  (nxt_cur),
    .nxt_live (nxt_live),
    .nxt_off  (nxt_off),
    .do_push  (do_push),
    .do_pop   (do_pop),
    .push_ent (push_ent),
    .go_back  (go_back),
    .fault    (fault)
  );

  assign accept = op_valid && !fault;

  for (genvar g = 0; g < WAVES; g++) begin : g_wave
    logic mine;
    assign mine = accept && (wave_sel == WSW'(g));

    simt_wave_ctx #(.LANES(LANES), .DEPTH(DEPTH), .SPW(SPW), .EW(EW)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (mine),
      .push     (do_push),
      .pop      (do_pop),
      .nxt_cur  (nxt_cur),
      .nxt_live (nxt_live),
      .nxt_off  (nxt_off),
      .push_ent (push_ent),
      .cur      (w_cur[g]),
      .live     (w_live[g]),
      .off      (w_off[g]),
      .top      (w_top[g]),
      .sp       (w_sp[g])
    );

    // R9
    other_wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && wave_sel == WSW'(g)) |=> $stable(w_cur[g]) && $stable(w_sp[g]));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && fault && wave_sel == WSW'(g)) |=> $stable(w_cur[g]) && $stable(w_sp[g]));

    // R2
    narrow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mine && (op_code == 3'(OP_IF) || op_code == 3'(OP_BREAK) || op_code == 3'(OP_CONT)))
      |=> ((w_cur[g] & ~$past(w_cur[g])) == '0));
  end

  assign active_mask = w_cur[wave_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_back <= 1'b0;
      stack_err <= 1'b0;
    end else begin
      loop_back <= accept && go_back;
      stack_err <= stack_err || (op_valid && fault);
    end
  end

  // R7
  loop_back_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_back |-> ($past(op_valid) && $past(op_code) == 3'(OP_ENDLOOP)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

endmodule

// File: tb/tb_simt_div_mask.sv
module tb_simt_div_mask;

  localparam bit [2:0] C_IF = 3'd0, C_ELSE = 3'd1, C_ENDIF = 3'd2, C_LOOP = 3'd3,
                       C_BRK = 3'd4, C_CONT = 3'd5, C_ENDLOOP = 3'd6, C_NONE = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = C_NONE;
  logic [1:0]  wave_sel = '0;
  logic [31:0] pred_bank = '0;
  logic [1:0]  pred_sel = '0;
  logic        pred_neg = 1'b0;
  logic [7:0]  active_mask;
  logic        loop_back, stack_err;

  always #10 clk = ~clk;

  simt_div_mask dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wave_sel(wave_sel), .pred_bank(pred_bank), .pred_sel(pred_sel),
    .pred_neg(pred_neg), .active_mask(active_mask), .loop_back(loop_back),
    .stack_err(stack_err)
  );

  // Reference model: one record per stack frame, kept as a queue per wave.
  typedef struct { bit is_loop; bit [7:0] saved; bit [7:0] aux; bit [7:0] outer_off; } frame_t;
  frame_t   frames [4][$];
  bit [7:0] m_cur [4], m_live [4], m_off [4];
  bit       m_lb, m_err;
  int       vectors = 0, miscompares = 0;
  bit       done = 1'b0;

  task automatic compare(input int w, input string tag);
    vectors++;
    if (active_mask !== m_cur[w]) begin
      miscompares++;
      $display("FAIL %s wave %0d active_mask got %b expected %b", tag, w, active_mask, m_cur[w]);
    end
    if (loop_back !== m_lb) begin
      miscompares++;
      $display("FAIL %s wave %0d loop_back got %b expected %b", tag, w, loop_back, m_lb);
    end
    if (stack_err !== m_err) begin
      miscompares++;
      $display("FAIL %s wave %0d stack_err got %b expected %b", tag, w, stack_err, m_err);
    end
  endtask

  task automatic model(input int w, input bit v, input bit [2:0] c, input bit [7:0] p);
    bit [7:0] hit;
    frame_t   f;
    int       depth;
    m_lb  = 1'b0;
    if (!v) return;
    depth = frames[w].size();
    hit   = m_cur[w] & p;
    if (depth > 0) f = frames[w][depth-1];
    case (c)
      C_IF: if (depth >= 32) m_err = 1; else begin
        frames[w].push_back('{0, m_cur[w], hit, 8'h00});
        m_cur[w] = hit;
      end
      C_ELSE: if (depth == 0 || f.is_loop) m_err = 1;
              else m_cur[w] = f.saved & ~f.aux & ~m_off[w];
      C_ENDIF: if (depth == 0 || f.is_loop) m_err = 1; else begin
        m_cur[w] = f.saved & ~m_off[w];
        void'(frames[w].pop_back());
      end
      C_LOOP: if (depth >= 32) m_err = 1; else begin
        frames[w].push_back('{1, m_cur[w], m_live[w], m_off[w]});
        m_live[w] = m_cur[w];
        m_off[w]  = 0;
      end
      C_BRK: begin
        m_live[w] &= ~hit; m_off[w] |= hit; m_cur[w] &= ~p;
      end
      C_CONT: begin
        m_off[w] |= hit; m_cur[w] &= ~p;
      end
      C_ENDLOOP: if (depth == 0 || !f.is_loop) m_err = 1;
        else if (m_live[w] != 0) begin
          m_lb = 1; m_cur[w] = m_live[w]; m_off[w] = 0;
        end else begin
          m_cur[w] = f.saved; m_live[w] = f.aux; m_off[w] = f.outer_off;
          void'(frames[w].pop_back());
        end
      default: ;
    endcase
  endtask

  // One cycle: drive at negedge, let the edge pass, update model, compare.
  task automatic step(input int w, input bit v, input bit [2:0] c, input bit [31:0] bank,
                      input bit [1:0] ps, input bit ng, input string tag);
    bit [7:0] p;
    @(negedge clk);
    op_valid = v; op_code = c; wave_sel = 2'(w);
    pred_bank = bank; pred_sel = ps; pred_neg = ng;
    @(posedge clk);
    #5;
    op_valid = 1'b0;
    p = bank[ps*8 +: 8] ^ {8{ng}};
    model(w, v, c, p);
    compare(w, tag);
  endtask

  task automatic idle(input int w, input string tag);
    step(w, 1'b0, C_IF, 32'h0, 2'd0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 4; w++) begin
      m_cur[w] = 8'hFF; m_live[w] = 8'hFF; m_off[w] = 8'h00;
    end
    m_lb = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R1 reset state on every wave
    for (int w = 0; w < 4; w++) idle(w, "R1 reset");

    // R2 R3 R4 single conditional, register 1 = A6
    step(0, 1, C_IF,    32'h0000_A600, 2'd1, 0, "R2 if plain");
    step(0, 1, C_ELSE,  32'h0,         2'd0, 0, "R3 else");
    step(0, 1, C_ENDIF, 32'h0,         2'd0, 0, "R4 endif");
    // R2 inverted register 2 = 0F -> F0
    step(0, 1, C_IF,    32'h000F_0000, 2'd2, 1, "R2 if negated");
    // nested conditional inside, register 3 = 3C
    step(0, 1, C_IF,    32'h3C00_0000, 2'd3, 0, "R2 nested if");
    step(0, 1, C_ELSE,  32'h0,         2'd0, 0, "R3 nested else");
    step(0, 1, C_ENDIF, 32'h0,         2'd0, 0, "R4 nested endif");
    step(0, 1, C_ELSE,  32'h0,         2'd0, 0, "R3 outer else");
    step(0, 1, C_ENDIF, 32'h0,         2'd0, 0, "R4 outer endif");
    // R11 invalid and code 7 have no effect
    step(0, 0, C_IF,    32'h0,         2'd0, 0, "R11 op_valid low");
    step(0, 1, C_NONE,  32'h0,         2'd0, 0, "R11 code 7");

    // R5 R6 R7 loop with direct break and continue
    step(1, 1, C_LOOP,    32'h0,  2'd0, 0, "R7 loop open");
    step(1, 1, C_BRK,     32'h03, 2'd0, 0, "R5 break lanes 0,1");
    step(1, 1, C_CONT,    32'h04, 2'd0, 0, "R6 continue lane 2");
    step(1, 1, C_ENDLOOP, 32'h0,  2'd0, 0, "R7 endloop back");
    step(1, 1, C_CONT,    32'h30, 2'd0, 0, "R6 continue lanes 4,5");
    step(1, 1, C_ENDLOOP, 32'h0,  2'd0, 0, "R6 continued lanes return");
    step(1, 1, C_BRK,     32'h0,  2'd0, 1, "R5 break negated all");
    step(1, 1, C_ENDLOOP, 32'h0,  2'd0, 0, "R7 endloop exit");

    // R3 R4 R5 break inside a conditional inside a loop
    step(2, 1, C_LOOP,    32'h0,  2'd0, 0, "R7 loop open w2");
    step(2, 1, C_IF,      32'h0F, 2'd0, 0, "R2 if in loop");
    step(2, 1, C_BRK,     32'h03, 2'd0, 0, "R5 break in if");
    step(2, 1, C_ELSE,    32'h0,  2'd0, 0, "R3 else after break");
    step(2, 1, C_CONT,    32'h40, 2'd0, 0, "R6 continue in else");
    step(2, 1, C_ENDIF,   32'h0,  2'd0, 0, "R4 endif keeps broken out");
    step(2, 1, C_ENDLOOP, 32'h0,  2'd0, 0, "R7 back without broken");
    // R9 other waves untouched meanwhile
    idle(0, "R9 wave0 intact");
    idle(3, "R9 wave3 intact");
    step(3, 1, C_IF,      32'h0100_0000, 2'd3, 0, "R9 wave3 if");
    idle(2, "R9 wave2 intact");
    step(2, 1, C_BRK,     32'h0,  2'd0, 1, "R5 break rest w2");
    step(2, 1, C_ENDLOOP, 32'h0,  2'd0, 0, "R7 exit w2");
    step(3, 1, C_ENDIF,   32'h0,  2'd0, 0, "R4 wave3 endif");

    // R10 underflow and mismatch leave state alone
    step(2, 1, C_IF,      32'h55, 2'd0, 0, "R2 if w2");
    step(2, 1, C_ENDLOOP, 32'h0,  2'd0, 0, "R10 mismatch endloop");
    step(2, 1, C_ENDIF,   32'h0,  2'd0, 0, "R4 endif w2");
    step(2, 1, C_ENDIF,   32'h0,  2'd0, 0, "R10 underflow endif");
    step(2, 1, C_ELSE,    32'h0,  2'd0, 0, "R10 underflow else");

    // R8 full depth on wave 3, alternating if and loop
    for (int i = 0; i < 32; i++)
      step(3, 1, (i % 2 == 0) ? C_LOOP : C_IF, 32'hFF, 2'd0, 0, "R8 push");
    step(3, 1, C_IF, 32'h0, 2'd0, 0, "R10 overflow leaves mask");
    step(3, 1, C_CONT, 32'h81, 2'd0, 0, "R6 continue deep");
    for (int i = 31; i >= 0; i--) begin
      if (i % 2 == 1) step(3, 1, C_ENDIF, 32'h0, 2'd0, 0, "R8 pop if");
      else begin
        step(3, 1, C_ENDLOOP, 32'h0,  2'd0, 0, "R8 endloop deep");
        step(3, 1, C_BRK,     32'hFF, 2'd0, 0, "R5 break deep");
        step(3, 1, C_ENDLOOP, 32'h0,  2'd0, 0, "R8 pop loop");
      end
    end
    idle(3, "R8 unwound");
    idle(1, "R9 wave1 intact");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule